// File: doc/BRIEF.md
# Transactional Cache Snoop Responder

This block sits on the bus side of a small, fully associative transactional cache. Each cycle it may receive one snooped bus request: a regular read, a regular read-for-ownership, a transactional read or a transactional read-for-ownership. It compares the request address with every entry of the cache at once. It then decides, from the request kind and from each matching entry's transaction tag and coherence state, what to do:

- supply the entry's data,
- move matching entries to a new coherence state,
- refuse the request with a BUSY answer, so that the remote transaction aborts and retries, or
- abort the local transaction.

The entry array is held outside the block. Its address, tag, coherence state and data fields arrive here as flat vectors. The block sends back a set of per-entry update enables and one shared new coherence state. All responses and commands are registered. They appear exactly one cycle after the request is sampled, as single-cycle pulses.

Top module: `tcs_snoop_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero on the following cycle, even when a snoop request is presented.
- R2: A regular read (`snp_kind`=0) that hits drives `rsp_data_vld`=1 with the selected entry's data. It also sets `upd_en` for exactly the hit entries, with `upd_coh`=1 (valid).
- R3: A regular read-for-ownership (`snp_kind`=1) that hits drives `rsp_data_vld`=1 with the selected data. It also sets `upd_en` for exactly the hit entries, with `upd_coh`=0 (invalid).
- R4: A transactional read (`snp_kind`=2) whose hit entries are all in the valid state (coh 1) supplies data, whatever their tags. It leaves `upd_en` at zero.
- R5: A transactional read that hits any entry in dirty (coh 2) or reserved (coh 3) gives `rsp_busy`=1 and `rsp_data_vld`=0. It issues no update.
- R6: A transactional read-for-ownership (`snp_kind`=3) that hits any entry gives `rsp_busy`=1, whatever the tag or state. It issues no update.
- R7: A regular read or read-for-ownership that hits an entry tagged commit-discard (tag 2) or abort-discard (tag 3) pulses `tx_abort` in the same cycle as its data response. It is otherwise served as for a normal (tag 1) entry.
- R8: An entry counts as a hit only when its address equals `snp_addr`, its tag is not empty (tag 0) and its coherence state is not invalid (coh 0). A request with no hit gives no response, no update and no abort.
- R9: The supplied data comes from the lowest-index hit entry whose tag is not abort-discard. If every hit is abort-discard, it comes from the lowest-index hit.
- R10: A response appears on the cycle right after the request is sampled and lasts one cycle. With `snp_valid` low, every output returns to zero, and `rsp_data` is zero whenever `rsp_data_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Snooped request present this cycle |
| snp_kind | input | 2 | 0 read, 1 read-for-ownership, 2 transactional read, 3 transactional read-for-ownership |
| snp_addr | input | ADDR_W | Snooped line address |
| ent_addr | input | N_ENTRIES*ADDR_W | Entry addresses, entry i at bits [i*ADDR_W +: ADDR_W] |
| ent_tag | input | N_ENTRIES*2 | Entry transaction tags: 0 empty, 1 normal, 2 commit-discard, 3 abort-discard |
| ent_coh | input | N_ENTRIES*2 | Entry coherence: 0 invalid, 1 valid, 2 dirty, 3 reserved |
| ent_data | input | N_ENTRIES*DATA_W | Entry data words |
| rsp_data_vld | output | 1 | Data supplied to the bus |
| rsp_busy | output | 1 | BUSY refusal to the bus |
| rsp_data | output | DATA_W | Supplied data |
| upd_en | output | N_ENTRIES | Entries whose coherence state is to be written |
| upd_coh | output | 2 | New coherence state for the enabled entries |
| tx_abort | output | 1 | Clear the local transaction status |

## Verification
A regular read or read-for-ownership that hits a transactional line makes the data supply and the local abort fall in the same cycle. The per-entry state write comes with them. The bench provokes this with a pair of entries at one address: a commit-discard entry holding the old value at a high index and an abort-discard entry holding the tentative value at a lower index. A second case has only an abort-discard entry. Each case is judged by requiring `tx_abort` and `rsp_data_vld` together one cycle after the request, with the old value chosen over the tentative one and both entries named in `upd_en`.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_RFO   = 2'd1,
    REQ_TREAD = 2'd2,
    REQ_TRFO  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    TAG_EMPTY   = 2'd0,
    TAG_NORMAL  = 2'd1,
    TAG_XCOMMIT = 2'd2,
    TAG_XABORT  = 2'd3
  } tx_tag_e;

  typedef enum logic [1:0] {
    COH_INVALID  = 2'd0,
    COH_VALID    = 2'd1,
    COH_DIRTY    = 2'd2,
    COH_RESERVED = 2'd3
  } coh_e;
endpackage

// File: rtl/tcs_match.sv
module tcs_match #(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 16
) (
  input  logic [ADDR_W-1:0]           snp_addr,
  input  logic [N_ENTRIES*ADDR_W-1:0] ent_addr,
  input  logic [N_ENTRIES*2-1:0]      ent_tag,
  input  logic [N_ENTRIES*2-1:0]      ent_coh,
  output logic [N_ENTRIES-1:0]        hit,
  output logic [N_ENTRIES-1:0]        hit_xtag,
  output logic [N_ENTRIES-1:0]        hit_owned,
  output logic [N_ENTRIES-1:0]        hit_xabort
);
  import tcs_pkg::*;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    logic [1:0] tag_i;
    logic [1:0] coh_i;
    assign tag_i = ent_tag[i*2 +: 2];
    assign coh_i = ent_coh[i*2 +: 2];
    // An entry takes part only when it holds a line in a live coherence state (R8)
    assign hit[i] = (ent_addr[i*ADDR_W +: ADDR_W] == snp_addr) &&
                    (tag_i != TAG_EMPTY) && (coh_i != COH_INVALID);
    assign hit_xtag[i]   = hit[i] && ((tag_i == TAG_XCOMMIT) || (tag_i == TAG_XABORT));
    assign hit_xabort[i] = hit[i] && (tag_i == TAG_XABORT);
    assign hit_owned[i]  = hit[i] && ((coh_i == COH_DIRTY) || (coh_i == COH_RESERVED));
  end
endmodule

// File: rtl/tcs_decide.sv
module tcs_decide #(
  parameter int N_ENTRIES = 8
) (
  input  logic                 req_valid,
  input  logic [1:0]           req_kind,
  input  logic [N_ENTRIES-1:0] hit,
  input  logic [N_ENTRIES-1:0] hit_xtag,
  input  logic [N_ENTRIES-1:0] hit_owned,
  output logic                 dec_data,
  output logic                 dec_busy,
  output logic                 dec_abort,
  output logic [N_ENTRIES-1:0] dec_upd,
  output logic [1:0]           dec_coh
);
  import tcs_pkg::*;

  logic any_hit, any_x, any_own;
  assign any_hit = |hit;
  assign any_x   = |hit_xtag;
  assign any_own = |hit_owned;

  always_comb begin
    dec_data  = 1'b0;
    dec_busy  = 1'b0;
    dec_abort = 1'b0;
    dec_upd   = '0;
    dec_coh   = COH_INVALID;
    if (req_valid && any_hit) begin
      unique case (req_kind)
        REQ_READ: begin            // R2: downgrade to shared and supply
          dec_data  = 1'b1;
          dec_upd   = hit;
          dec_coh   = COH_VALID;
          dec_abort = any_x;       // R7
        end
        REQ_RFO: begin             // R3: give up the line and supply
          dec_data  = 1'b1;
          dec_upd   = hit;
          dec_coh   = COH_INVALID;
          dec_abort = any_x;       // R7
        end
        REQ_TREAD: begin           // R4 / R5
          dec_busy = any_own;
          dec_data = !any_own;
        end
        default: begin             // R6: transactional ownership request refused
          dec_busy = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/tcs_select.sv
module tcs_select #(
  parameter int N_ENTRIES = 8,
  parameter int DATA_W    = 32
) (
  input  logic [N_ENTRIES-1:0]        hit,
  input  logic [N_ENTRIES-1:0]        hit_xabort,
  input  logic [N_ENTRIES*DATA_W-1:0] ent_data,
  output logic [DATA_W-1:0]           sel_data
);
  logic [N_ENTRIES-1:0] pref;
  assign pref = hit & ~hit_xabort;

  // R9: committed value first, lowest index wins; tentative value only as fallback
  always_comb begin
    sel_data = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) sel_data = ent_data[i*DATA_W +: DATA_W];
    end
    if (|pref) begin
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
        if (pref[i]) sel_data = ent_data[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/tcs_snoop_top.sv
module tcs_snoop_top #(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          snp_valid,
  input  logic [1:0]                    snp_kind,
  input  logic [ADDR_W-1:0]             snp_addr,
  input  logic [N_ENTRIES*ADDR_W-1:0]   ent_addr,
  input  logic [N_ENTRIES*2-1:0]        ent_tag,
  input  logic [N_ENTRIES*2-1:0]        ent_coh,
  input  logic [N_ENTRIES*DATA_W-1:0]   ent_data,
  output logic                          rsp_data_vld,
  output logic                          rsp_busy,
  output logic [DATA_W-1:0]             rsp_data,
  output logic [N_ENTRIES-1:0]          upd_en,
  output logic [1:0]                    upd_coh,
  output logic                          tx_abort
);
  logic [N_ENTRIES-1:0] hit, hit_xtag, hit_owned, hit_xabort;
  logic                 dec_data, dec_busy, dec_abort;
  logic [N_ENTRIES-1:0] dec_upd;
  logic [1:0]           dec_coh;
  logic [DATA_W-1:0]    sel_data;

  tcs_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .snp_addr  (snp_addr),
    .ent_addr  (ent_addr),
    .ent_tag   (ent_tag),
    .ent_coh   (ent_coh),
    .hit       (hit),
    .hit_xtag  (hit_xtag),
    .hit_owned (hit_owned),
    .hit_xabort(hit_xabort)
  );

  tcs_decide #(.N_ENTRIES(N_ENTRIES)) u_decide (
    .req_valid(snp_valid),
    .req_kind (snp_kind),
    .hit      (hit),
    .hit_xtag (hit_xtag),
    .hit_owned(hit_owned),
    .dec_data (dec_data),
    .dec_busy (dec_busy),
    .dec_abort(dec_abort),
    .dec_upd  (dec_upd),
    .dec_coh  (dec_coh)
  );

  tcs_select #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W)) u_select (
    .hit       (hit),
    .hit_xabort(hit_xabort),
    .ent_data  (ent_data),
    .sel_data  (sel_data)
  );

  // R10: one register stage between the sampled request and every output
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_data_vld <= 1'b0;
      rsp_busy     <= 1'b0;
      rsp_data     <= '0;
      upd_en       <= '0;
      upd_coh      <= '0;
      tx_abort     <= 1'b0;
    end else begin
      rsp_data_vld <= dec_data;
      rsp_busy     <= dec_busy;
      rsp_data     <= dec_data ? sel_data : '0;
      upd_en       <= dec_upd;
      upd_coh      <= dec_coh;
      tx_abort     <= dec_abort;
    end
  end

  assert_busy_data_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(rsp_busy && rsp_data_vld));

  assert_busy_no_update_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_busy |-> (upd_en == '0));

  assert_abort_with_data_R7: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> rsp_data_vld);

  assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_busy || rsp_data_vld) |-> $past(snp_valid));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(snp_valid) |-> (upd_en == '0 && !tx_abort && rsp_data == '0));
endmodule

// File: tb/tcs_snoop_top_tb.sv
module tcs_snoop_top_tb;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int DW = 32;

  typedef struct {
    logic          dv;
    logic          busy;
    logic [DW-1:0] data;
    logic [N-1:0]  upd;
    logic [1:0]    coh;
    logic          abort;
    string         req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snp_valid = 1'b0;
  logic [1:0] snp_kind = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [N*AW-1:0] ent_addr_f;
  logic [N*2-1:0]  ent_tag_f, ent_coh_f;
  logic [N*DW-1:0] ent_data_f;
  logic rsp_data_vld, rsp_busy, tx_abort;
  logic [DW-1:0] rsp_data;
  logic [N-1:0] upd_en;
  logic [1:0] upd_coh;

  logic [AW-1:0] e_addr [N];
  logic [1:0]    e_tag  [N];
  logic [1:0]    e_coh  [N];
  logic [DW-1:0] e_data [N];
  logic [AW-1:0] s_addr [N];
  logic [1:0]    s_tag  [N];
  logic [1:0]    s_coh  [N];
  logic [DW-1:0] s_data [N];

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_addr_f[i*AW +: AW] = e_addr[i];
      ent_tag_f[i*2 +: 2]    = e_tag[i];
      ent_coh_f[i*2 +: 2]    = e_coh[i];
      ent_data_f[i*DW +: DW] = e_data[i];
    end
  end

  tcs_snoop_top #(.N_ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_kind(snp_kind),
    .snp_addr(snp_addr), .ent_addr(ent_addr_f), .ent_tag(ent_tag_f),
    .ent_coh(ent_coh_f), .ent_data(ent_data_f), .rsp_data_vld(rsp_data_vld),
    .rsp_busy(rsp_busy), .rsp_data(rsp_data), .upd_en(upd_en),
    .upd_coh(upd_coh), .tx_abort(tx_abort)
  );

  // Expected outcome worked out from the requirements
  function automatic exp_t model(logic v, logic [1:0] k, logic [AW-1:0] a, string nm);
    exp_t e;
    logic [N-1:0] h;
    logic own, xt, have_pref;
    e.dv = 0; e.busy = 0; e.data = '0; e.upd = '0; e.coh = 2'd0; e.abort = 0; e.req = nm;
    own = 0; xt = 0; have_pref = 0;
    for (int i = 0; i < N; i++) begin
      h[i] = (e_addr[i] == a) && (e_tag[i] != 2'd0) && (e_coh[i] != 2'd0);
      if (h[i] && e_coh[i] >= 2'd2) own = 1;
      if (h[i] && e_tag[i] >= 2'd2) xt = 1;
    end
    if (!v || h == '0) return e;
    for (int i = 0; i < N; i++) begin
      if (h[i] && e_tag[i] != 2'd3 && !have_pref) begin e.data = e_data[i]; have_pref = 1; end
    end
    if (!have_pref) begin
      for (int i = N - 1; i >= 0; i--) if (h[i]) e.data = e_data[i];
    end
    case (k)
      2'd0: begin e.dv = 1; e.upd = h; e.coh = 2'd1; e.abort = xt; end
      2'd1: begin e.dv = 1; e.upd = h; e.coh = 2'd0; e.abort = xt; end
      2'd2: begin e.busy = own; e.dv = !own; end
      default: e.busy = 1;
    endcase
    if (!e.dv) e.data = '0;
    return e;
  endfunction

  task automatic drive(logic v, logic [1:0] k, logic [AW-1:0] a, string nm);
    @(negedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      e_addr[i] = s_addr[i]; e_tag[i] = s_tag[i]; e_coh[i] = s_coh[i]; e_data[i] = s_data[i];
    end
    snp_valid = v; snp_kind = k; snp_addr = a;
    q.push_back(model(v, k, a, nm));
  endtask

  task automatic set_ent(int i, logic [AW-1:0] a, logic [1:0] t, logic [1:0] c, logic [DW-1:0] d);
    s_addr[i] = a; s_tag[i] = t; s_coh[i] = c; s_data[i] = d;
  endtask

  // Monitor: compare each cycle's outputs with the item queued one cycle earlier
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rsp_data_vld !== e.dv || rsp_busy !== e.busy || rsp_data !== e.data ||
          upd_en !== e.upd || upd_coh !== e.coh || tx_abort !== e.abort) begin
        fails++;
        $display("FAIL %s: act dv=%b busy=%b data=%h upd=%b coh=%0d abort=%b exp dv=%b busy=%b data=%h upd=%b coh=%0d abort=%b",
                 e.req, rsp_data_vld, rsp_busy, rsp_data, upd_en, upd_coh, tx_abort,
                 e.dv, e.busy, e.data, e.upd, e.coh, e.abort);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      set_ent(i, '0, 2'd0, 2'd0, '0);
      e_addr[i] = '0; e_tag[i] = 2'd0; e_coh[i] = 2'd0; e_data[i] = '0;
    end
    set_ent(0, 16'h0100, 2'd1, 2'd2, 32'hAAAA_0001);
    for (int i = 0; i < N; i++) begin
      e_addr[i] = s_addr[i]; e_tag[i] = s_tag[i]; e_coh[i] = s_coh[i]; e_data[i] = s_data[i];
    end
    // R1: a request during reset must not reach the outputs
    snp_valid = 1; snp_kind = 2'd0; snp_addr = 16'h0100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_data_vld !== 0 || rsp_busy !== 0 || rsp_data !== '0 || upd_en !== '0 ||
        upd_coh !== 0 || tx_abort !== 0) begin
      fails++;
      $display("FAIL R1: act dv=%b busy=%b upd=%b exp all zero", rsp_data_vld, rsp_busy, upd_en);
    end
    snp_valid = 0;
    @(posedge clk);
    #1 rst = 0;

    // R2: regular read on a normal dirty line
    drive(1, 2'd0, 16'h0100, "R2 read normal dirty");
    // R3: read-for-ownership on a normal valid line
    set_ent(1, 16'h0200, 2'd1, 2'd1, 32'hBBBB_0002);
    drive(1, 2'd1, 16'h0200, "R3 rfo normal valid");
    // R4: transactional read on a valid commit-discard line
    set_ent(2, 16'h0300, 2'd2, 2'd1, 32'hCCCC_0003);
    drive(1, 2'd2, 16'h0300, "R4 tread valid xcommit");
    // R5: transactional read on a reserved line
    set_ent(3, 16'h0400, 2'd3, 2'd3, 32'hDDDD_0004);
    drive(1, 2'd2, 16'h0400, "R5 tread reserved");
    // R6: transactional ownership request on a valid line
    drive(1, 2'd3, 16'h0200, "R6 trfo valid");
    // R7 and R9: old value at index 5, tentative value at index 4, same address
    set_ent(4, 16'h0500, 2'd3, 2'd3, 32'h7E47_0004);
    set_ent(5, 16'h0500, 2'd2, 2'd3, 32'h01D0_0005);
    drive(1, 2'd0, 16'h0500, "R7 R9 read hits pair");
    drive(1, 2'd1, 16'h0500, "R7 R9 rfo hits pair");
    // R7 and R9: only an abort-discard line hits
    drive(1, 2'd1, 16'h0400, "R7 R9 rfo only xabort");
    // R5: valid and dirty lines at one address
    set_ent(6, 16'h0600, 2'd1, 2'd1, 32'h6666_0006);
    set_ent(7, 16'h0600, 2'd2, 2'd2, 32'h7777_0007);
    drive(1, 2'd2, 16'h0600, "R5 tread mixed pair");
    drive(1, 2'd3, 16'h0600, "R6 trfo mixed pair");
    // R8: matching address on an empty-tag line and on an invalid line
    set_ent(6, 16'h0700, 2'd0, 2'd2, 32'h1111_0000);
    set_ent(7, 16'h0800, 2'd1, 2'd0, 32'h2222_0000);
    drive(1, 2'd0, 16'h0700, "R8 empty tag");
    drive(1, 2'd1, 16'h0800, "R8 invalid coh");
    drive(1, 2'd3, 16'h0900, "R8 no address match");
    // R10: idle with a hitting address present, then back-to-back requests
    drive(0, 2'd0, 16'h0100, "R10 idle");
    drive(1, 2'd0, 16'h0100, "R10 b2b first");
    drive(1, 2'd2, 16'h0500, "R10 b2b second");
    drive(0, 2'd0, 16'h0000, "R10 trailing idle");
    drive(0, 2'd0, 16'h0000, "R10 trailing idle");
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule